// File: doc/BRIEF.md
# Effective-Address Byte Parser

This unit sits behind an instruction decoder that has already consumed an opcode. It takes the addressing bytes that follow the opcode as a byte stream and parses them into the operand an instruction should use. That operand is either a register selected directly, or a 32-bit memory address formed from a base register, a scaled index register and a displacement.

The stream runs on a valid/ready handshake. A byte moves only in a cycle where `s_valid` and `s_ready` are both high. The sender may hold `s_valid` low for any number of cycles between bytes, and the unit has no limit on how long it waits. The unit holds `s_ready` low while it presents a result and afterwards until `start` is pulsed. This back-pressure prevents the next instruction's bytes from merging into the current parse.

When the last byte is consumed, the unit raises `done` for exactly one cycle. During that cycle it presents the result: the register-direct flag and selector, the effective address, the pass-through register field, and the number of bytes it consumed. The register file snapshot `gpr_flat` must stay stable from the first byte until `done`.

Top module: `addr_mode_parser`

## Requirements
- R1: After a synchronous reset the unit waits for a first addressing byte: `s_ready` is 1 and `done` is 0.
- R2: A byte is consumed only when `s_valid` and `s_ready` are both high. From the `done` cycle until a `start` pulse, `s_ready` stays 0 and bytes offered are not consumed.
- R3: The first byte is split into mode (bits 7:6), reg (bits 5:3) and rm (bits 2:0). Mode 3 gives `is_reg`=1, `reg_sel`=rm, `eff_addr`=0 and a byte count of 1.
- R4: Mode 0 with rm not equal to 4 or 5 gives `eff_addr` = register rm and a byte count of 1. Register code n is the n-th 32-bit word of `gpr_flat` (0=eax, 1=ecx, 2=edx, 3=ebx, 4=esp, 5=ebp, 6=esi, 7=edi).
- R5: Mode 1 takes one displacement byte. That byte is sign-extended and added to the base.
- R6: Mode 2 takes a 32-bit displacement, received least-significant byte first, and adds it to the base.
- R7: In modes 0 to 2, rm=4 means a second byte follows, with scale in bits 7:6, index in bits 5:3 and base in bits 2:0. The address is base + (index << scale) + displacement.
- R8: A second-byte index of 4 adds no index term.
- R9: Mode 0 with rm=5 uses no base register, takes a 32-bit displacement and gives a byte count of 5.
- R10: Mode 0 with a second byte whose base is 5 uses no base register, takes a 32-bit displacement and gives a byte count of 6.
- R11: `reg_field` reports the reg bits of the first byte unchanged, in every mode.
- R12: `done` is high for exactly one cycle per parse, and `byte_count` then equals the number of bytes consumed (1 to 6).
- R13: Address arithmetic wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Re-arms the parser after a result has been presented |
| s_valid | input | 1 | Stream byte is valid |
| s_byte | input | 8 | Stream byte |
| s_ready | output | 1 | Parser can accept a byte |
| gpr_flat | input | 256 | Eight 32-bit general registers, register n in bits [32n+31:32n] |
| done | output | 1 | One-cycle pulse with the parse result |
| is_reg | output | 1 | Operand is a register, not memory |
| reg_sel | output | 3 | Selected register when `is_reg` is 1 |
| eff_addr | output | 32 | Effective memory address |
| reg_field | output | 3 | Reg bits of the first byte |
| byte_count | output | 3 | Number of addressing bytes consumed |

## Verification
The bench targets the escape codes. A parser that treated rm=4 as a plain register would stop after one byte and return esp's value. A parser that missed the mode-0 base-5 rule, with or without a second byte, would add ebp and read too few bytes. A parser that ignored index 4 would add esp into the sum.

Negative one-byte displacements catch a missing sign extension, which shows up as an address about 256 high. A 32-bit displacement with four distinct bytes catches byte reversal. A sum chosen to overflow catches wrong carry handling. Random gaps in `s_valid`, and bytes offered after `done`, catch a parser that consumes bytes it should have refused.

// File: rtl/eadec_pkg.sv
package eadec_pkg;
  typedef enum logic [1:0] {
    NX_DONE = 2'd0,
    NX_SIB  = 2'd1,
    NX_D8   = 2'd2,
    NX_D32  = 2'd3
  } next_e;

  typedef enum logic [2:0] {
    ST_MODRM = 3'd0,
    ST_SIB   = 3'd1,
    ST_DISP  = 3'd2,
    ST_DONE  = 3'd3,
    ST_IDLE  = 3'd4
  } state_e;

  localparam logic [1:0] MODE_DIRECT = 2'd3;
  localparam logic [2:0] CODE_ESCAPE = 3'd4;
  localparam logic [2:0] CODE_NOBASE = 3'd5;
endpackage

// File: rtl/eadec_step_decode.sv
module eadec_step_decode
  import eadec_pkg::*;
(
  input  logic [1:0] mode,
  input  logic [2:0] field,
  input  logic       in_sib,
  output next_e      nxt,
  output logic       no_base
);
  always_comb begin
    no_base = 1'b0;
    if (!in_sib && mode == MODE_DIRECT) begin
      nxt = NX_DONE;
    end else if (!in_sib && field == CODE_ESCAPE) begin
      nxt = NX_SIB;
    end else if (mode == 2'd0 && field == CODE_NOBASE) begin
      nxt     = NX_D32;
      no_base = 1'b1;
    end else begin
      case (mode)
        2'd1:    nxt = NX_D8;
        2'd2:    nxt = NX_D32;
        default: nxt = NX_DONE;
      endcase
    end
  end
endmodule

// File: rtl/eadec_disp_acc.sv
module eadec_disp_acc #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          take,
  input  logic          wide,
  input  logic [7:0]    byte_in,
  output logic [DW-1:0] disp,
  output logic          last
);
  localparam int unsigned NB = DW / 8;
  localparam int unsigned CW = (NB > 1) ? $clog2(NB) : 1;

  logic [CW-1:0] cnt;

  assign last = take && (!wide || cnt == CW'(NB - 1));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      disp <= '0;
      cnt  <= '0;
    end else if (take) begin
      if (!wide) disp <= {{(DW-8){byte_in[7]}}, byte_in};
      else       disp <= {byte_in, disp[DW-1:8]};
      cnt <= cnt + CW'(1);
    end
  end

  p_sext_r5: assert property (@(posedge clk) disable iff (rst)
    (take && !wide && !clr) |=> (disp[DW-1:8] == {(DW-8){$past(byte_in[7])}}));

  p_lsb_first_r6: assert property (@(posedge clk) disable iff (rst)
    (take && wide && !clr) |=> (disp[DW-1:DW-8] == $past(byte_in)));
endmodule

// File: rtl/eadec_agen.sv
module eadec_agen #(
  parameter int unsigned AW   = 32,
  parameter int unsigned NREG = 8
) (
  input  logic [NREG*AW-1:0]        gpr_flat,
  input  logic [$clog2(NREG)-1:0]   base_sel,
  input  logic                      base_en,
  input  logic [$clog2(NREG)-1:0]   idx_sel,
  input  logic                      idx_en,
  input  logic [1:0]                scale,
  input  logic [AW-1:0]             disp,
  output logic [AW-1:0]             ea
);
  logic [AW-1:0] gpr [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_unpack
    assign gpr[g] = gpr_flat[g*AW +: AW];
  end

  logic [AW-1:0] base_term, idx_term;

  assign base_term = base_en ? gpr[base_sel] : '0;
  assign idx_term  = idx_en  ? (gpr[idx_sel] << scale) : '0;
  assign ea        = base_term + idx_term + disp;
endmodule

// File: rtl/addr_mode_parser.sv
module addr_mode_parser
  import eadec_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          s_valid,
  input  logic [7:0]    s_byte,
  output logic          s_ready,
  input  logic [8*AW-1:0] gpr_flat,
  output logic          done,
  output logic          is_reg,
  output logic [2:0]    reg_sel,
  output logic [AW-1:0] eff_addr,
  output logic [2:0]    reg_field,
  output logic [2:0]    byte_count
);
  localparam int unsigned NREG = 8;

  state_e      state;
  logic [1:0]  mod_q;
  logic [2:0]  reg_q, rm_q;
  logic [7:0]  sib_q;
  logic        has_sib, no_base_q, wide_q;
  logic [2:0]  cnt_q;

  logic        take;
  next_e       nxt;
  logic        dec_no_base;
  logic [1:0]  dec_mode;
  logic [AW-1:0] disp;
  logic        disp_last;
  logic [AW-1:0] agen_ea;

  assign s_ready  = (state == ST_MODRM) || (state == ST_SIB) || (state == ST_DISP);
  assign take     = s_valid && s_ready;
  assign dec_mode = (state == ST_MODRM) ? s_byte[7:6] : mod_q;

  eadec_step_decode u_dec (
    .mode    (dec_mode),
    .field   (s_byte[2:0]),
    .in_sib  (state == ST_SIB),
    .nxt     (nxt),
    .no_base (dec_no_base)
  );

  eadec_disp_acc #(.DW(AW)) u_disp (
    .clk     (clk),
    .rst     (rst),
    .clr     (take && state == ST_MODRM),
    .take    (take && state == ST_DISP),
    .wide    (wide_q),
    .byte_in (s_byte),
    .disp    (disp),
    .last    (disp_last)
  );

  eadec_agen #(.AW(AW), .NREG(NREG)) u_agen (
    .gpr_flat (gpr_flat),
    .base_sel (has_sib ? sib_q[2:0] : rm_q),
    .base_en  (!no_base_q),
    .idx_sel  (sib_q[5:3]),
    .idx_en   (has_sib && sib_q[5:3] != CODE_ESCAPE),
    .scale    (sib_q[7:6]),
    .disp     (disp),
    .ea       (agen_ea)
  );

  function automatic state_e after_field(input next_e n);
    case (n)
      NX_SIB:  return ST_SIB;
      NX_D8,
      NX_D32:  return ST_DISP;
      default: return ST_DONE;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_MODRM;
      mod_q     <= '0;
      reg_q     <= '0;
      rm_q      <= '0;
      sib_q     <= '0;
      has_sib   <= 1'b0;
      no_base_q <= 1'b0;
      wide_q    <= 1'b0;
      cnt_q     <= '0;
    end else begin
      case (state)
        ST_MODRM: if (take) begin
          mod_q     <= s_byte[7:6];
          reg_q     <= s_byte[5:3];
          rm_q      <= s_byte[2:0];
          sib_q     <= '0;
          has_sib   <= 1'b0;
          no_base_q <= dec_no_base;
          wide_q    <= (nxt == NX_D32);
          cnt_q     <= 3'd1;
          state     <= after_field(nxt);
        end
        ST_SIB: if (take) begin
          sib_q     <= s_byte;
          has_sib   <= 1'b1;
          no_base_q <= dec_no_base;
          wide_q    <= (nxt == NX_D32);
          cnt_q     <= cnt_q + 3'd1;
          state     <= after_field(nxt);
        end
        ST_DISP: if (take) begin
          cnt_q <= cnt_q + 3'd1;
          if (disp_last) state <= ST_DONE;
        end
        ST_DONE: state <= ST_IDLE;
        default: if (start) state <= ST_MODRM;
      endcase
    end
  end

  assign done       = (state == ST_DONE);
  assign is_reg     = (mod_q == MODE_DIRECT);
  assign reg_sel    = rm_q;
  assign eff_addr   = is_reg ? '0 : agen_ea;
  assign reg_field  = reg_q;
  assign byte_count = cnt_q;

  p_reset_ready_r1: assert property (@(posedge clk)
    $past(rst) && !rst |-> (s_ready && !done));

  p_no_accept_r2: assert property (@(posedge clk) disable iff (rst)
    done |-> !s_ready);

  p_stay_idle_r2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !start) |=> !s_ready);

  p_direct_len_r3: assert property (@(posedge clk) disable iff (rst)
    (done && is_reg) |-> (byte_count == 3'd1 && eff_addr == '0));

  p_done_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_count_range_r12: assert property (@(posedge clk) disable iff (rst)
    done |-> (byte_count >= 3'd1 && byte_count <= 3'd6));

  p_long_count_r10: assert property (@(posedge clk) disable iff (rst)
    (done && has_sib && no_base_q) |-> (byte_count == 3'd6));
endmodule

// File: tb/sim_addr_mode_parser.sv
module sim_addr_mode_parser;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic s_valid = 1'b0;
  logic [7:0] s_byte = 8'h00;
  logic s_ready;
  logic [255:0] gpr_flat = '0;
  logic done, is_reg;
  logic [2:0] reg_sel, reg_field, byte_count;
  logic [31:0] eff_addr;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  addr_mode_parser u0 (
    .clk(clk), .rst(rst), .start(start), .s_valid(s_valid), .s_byte(s_byte),
    .s_ready(s_ready), .gpr_flat(gpr_flat), .done(done), .is_reg(is_reg),
    .reg_sel(reg_sel), .eff_addr(eff_addr), .reg_field(reg_field),
    .byte_count(byte_count)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] gr(input logic [2:0] n);
    return gpr_flat[n*32 +: 32];
  endfunction

  // Reference model built from the requirements
  task automatic model(input logic [7:0] b [6], output int len, output bit e_isreg,
                       output logic [31:0] e_ea);
    logic [1:0] md;
    logic [2:0] rm;
    int p, dsz;
    bit nob;
    logic [31:0] bterm, iterm, dv;
    md = b[0][7:6];
    rm = b[0][2:0];
    e_isreg = (md == 2'd3);
    if (e_isreg) begin
      len = 1; e_ea = 32'h0;
      return;
    end
    iterm = 32'h0;
    if (rm == 3'd4) begin
      p = 2;
      nob = (md == 2'd0 && b[1][2:0] == 3'd5);   // R10
      bterm = nob ? 32'h0 : gr(b[1][2:0]);
      if (b[1][5:3] != 3'd4) iterm = gr(b[1][5:3]) << b[1][7:6];  // R7 R8
    end else begin
      p = 1;
      nob = (md == 2'd0 && rm == 3'd5);          // R9
      bterm = nob ? 32'h0 : gr(rm);
    end
    dsz = (md == 2'd1) ? 1 : ((md == 2'd2 || nob) ? 4 : 0);
    if (dsz == 1) dv = {{24{b[p][7]}}, b[p]};    // R5
    else if (dsz == 4) dv = {b[p+3], b[p+2], b[p+1], b[p]};  // R6
    else dv = 32'h0;
    len = p + dsz;
    e_ea = bterm + iterm + dv;                   // R13 wraps
  endtask

  task automatic run_parse(input logic [7:0] b [6], input int gmax, input string tag);
    int len;
    bit e_isreg;
    logic [31:0] e_ea;
    model(b, len, e_isreg, e_ea);
    @(negedge clk); start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    for (int i = 0; i < len; i++) begin
      int gap;
      gap = (gmax > 0) ? int'($urandom_range(gmax, 0)) : 0;
      for (int g = 0; g < gap; g++) @(negedge clk);
      @(negedge clk);
      s_valid = 1'b1;
      s_byte  = b[i];
      while (!s_ready) @(negedge clk);
      @(posedge clk); #1 s_valid = 1'b0;
    end
    @(negedge clk);
    check({tag, " R12 done"}, 32'(done), 32'd1);
    check({tag, " R12 count"}, 32'(byte_count), 32'(len));
    check({tag, " R3 is_reg"}, 32'(is_reg), 32'(e_isreg));
    check({tag, " R11 reg_field"}, 32'(reg_field), 32'(b[0][5:3]));
    if (e_isreg) check({tag, " R3 reg_sel"}, 32'(reg_sel), 32'(b[0][2:0]));
    check({tag, " R7 eff_addr"}, eff_addr, e_ea);
    @(negedge clk);
    check({tag, " R12 done drop"}, 32'(done), 32'd0);
    check({tag, " R2 ready low"}, 32'(s_ready), 32'd0);
    s_valid = 1'b1;
    s_byte  = 8'hC0;
    @(negedge clk);
    @(negedge clk);
    check({tag, " R2 refused"}, 32'(s_ready), 32'd0);
    s_valid = 1'b0;
  endtask

  task automatic rand_regs();
    for (int r = 0; r < 8; r++) gpr_flat[r*32 +: 32] = $urandom();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] b [6];
    void'($urandom(32'd1234));
    rand_regs();
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check("R1 ready", 32'(s_ready), 32'd1);
    check("R1 done", 32'(done), 32'd0);

    // R3 register direct
    b = '{8'hD3, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    run_parse(b, 0, "direct");
    // R4 plain indirect through edx
    b = '{8'h02, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
    run_parse(b, 1, "indirect");
    // R5 negative disp8 through ebp
    b = '{8'h45, 8'hFC, 8'h00, 8'h00, 8'h00, 8'h00};
    run_parse(b, 2, "disp8neg");
    // R6 disp32 byte order
    b = '{8'h81, 8'h11, 8'h22, 8'h33, 8'h44, 8'h00};
    run_parse(b, 0, "disp32");
    // R9 absolute disp32
    b = '{8'h05, 8'h78, 8'h56, 8'h34, 8'h12, 8'h00};
    run_parse(b, 3, "absolute");
    // R10 second byte, no base, scaled index
    b = '{8'h04, 8'h8D, 8'hEF, 8'hBE, 8'hAD, 8'hDE};
    run_parse(b, 0, "nobase_sib");
    // R8 index 4 means no index
    b = '{8'h44, 8'h20, 8'h10, 8'h00, 8'h00, 8'h00};
    run_parse(b, 1, "noindex");
    // R13 wrap
    gpr_flat[0*32 +: 32] = 32'hFFFF_FFF0;
    gpr_flat[1*32 +: 32] = 32'h8000_0001;
    b = '{8'h84, 8'hC8, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
    run_parse(b, 0, "wrap");
    // Random parses
    for (int n = 0; n < 300; n++) begin
      rand_regs();
      for (int k = 0; k < 6; k++) b[k] = 8'($urandom());
      run_parse(b, 2, "random");
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule